// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects completion and data-ready events from the transfer engine of a serial bus master. It records them in a 16-bit status word and compares that word against an enable mask. A single level interrupt goes high whenever an enabled event is pending. Software can take the next event through a vector register. A read of that register returns the number of the lowest pending enabled event and retires it in the same access.

Two DMA request lines follow the receive-ready and transmit-ready events while the matching DMA enable is set. Turning on a DMA enable removes the matching interrupt enable, so that the event is serviced by exactly one agent. A revision parameter selects between an older register layout and a newer one. The older layout has a 5-bit enable field and no vectoring. The newer layout has a 6-bit enable field and a live vector register.

Register port: `reg_addr` 0 = enable, 1 = status, 2 = vector, 3 = DMA config. `reg_rdata` is combinational from the current state. A read side effect takes place at the clock edge that ends a cycle in which `reg_rd` is high.

Top module: `irq_status_vector`

## Requirements
- R1: `irq` is high exactly when (status AND enable) is non-zero. It reflects a state change from the cycle that follows the edge at which the change was stored.
- R2: With REVISION >= 0x34, reading address 2 returns the 1-based position of the lowest set bit of (status AND enable), or 0 if there is none. That status bit is cleared at the edge that ends the read.
- R3: With REVISION < 0x34, reading address 2 returns 0 and leaves the status unchanged.
- R4: A write to address 1 clears the status bits where the write data has a one, but only for bits 0, 1, 2 and 5 (mask 0x0027). All other status bits are left unchanged.
- R5: Status bit 3 (receive ready) is cleared by a pulse on `rx_rdy_clr`. Status bit 4 (transmit ready) is cleared by a pulse on `tx_rdy_clr`.
- R6: A write to address 0 keeps bits [4:0] when REVISION < 0x34 and bits [5:0] otherwise. Discarded bits read back as 0.
- R7: A write to address 3 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Bit 15 set also clears enable bit 3. Bit 7 set also clears enable bit 4. The other enable bits are left unchanged.
- R8: `dma_rx_req` equals receive DMA enable AND status bit 3. `dma_tx_req` equals transmit DMA enable AND status bit 4.
- R9: Reading address 1 returns the stored status with bit 12 replaced by `bus_busy`. Set pulses on bit 12 are not stored.
- R10: A set pulse takes priority over any clear (status write, vector read, ready clear) of the same bit in the same cycle.
- R11: Synchronous reset clears status, enable and DMA configuration and drives `irq`, `dma_rx_req` and `dma_tx_req` low.
- R12: A write to address 2 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 16 | One-cycle event set pulses, one per status bit |
| rx_rdy_clr | input | 1 | Clears status bit 3 |
| tx_rdy_clr | input | 1 | Clears status bit 4 |
| bus_busy | input | 1 | Bus busy level, shown at status bit 12 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt level |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds two copies that share one stimulus: one with REVISION = 0x34 and one with REVISION = 0x20. Every access therefore shows the new-layout behaviour and the legacy behaviour side by side. The newer copy covers vector ordering and the read-clear of the vector register, including event bits above the enable field and the reserved busy bit. The legacy copy covers the narrower enable field and the inert vector register. Directed cases drive a set pulse and a clear of the same bit in one cycle to exercise R10.

// File: rtl/isv_pkg.sv
package isv_pkg;

    localparam int STAT_W     = 16;
    localparam int ADDR_W     = 2;
    localparam int IDX_W      = $clog2(STAT_W + 1);
    localparam int REV_VECTOR = 8'h34;

    localparam int RX_BIT     = 3;
    localparam int TX_BIT     = 4;
    localparam int BUSY_BIT   = 12;
    localparam int DMA_RX_POS = 15;
    localparam int DMA_TX_POS = 7;

    localparam logic [STAT_W-1:0] SW_CLR_MASK = 16'h0027;
    localparam logic [STAT_W-1:0] STORE_MASK  = ~(16'h1 << BUSY_BIT);

    typedef enum logic [ADDR_W-1:0] {
        RA_ENABLE = 2'd0,
        RA_STATUS = 2'd1,
        RA_VECTOR = 2'd2,
        RA_DMA    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } dma_cfg_t;

    typedef struct packed {
        logic [STAT_W-1:0] set;
        logic [STAT_W-1:0] clr;
    } stat_upd_t;

    function automatic logic [STAT_W-1:0] enable_keep(input int rev);
        return (rev >= REV_VECTOR) ? 16'h003F : 16'h001F;
    endfunction

    function automatic logic [STAT_W-1:0] bit_at(input int pos);
        return 16'h1 << pos;
    endfunction

endpackage

// File: rtl/isv_prio_enc.sv
module isv_prio_enc
    import isv_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_in,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  onehot_o
);

    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_in[i]) begin
                idx_o       = IW'(i + 1);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/isv_cfg_regs.sv
module isv_cfg_regs
    import isv_pkg::*;
#(
    parameter int REVISION = REV_VECTOR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_enable,
    input  logic              wr_dma,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] enable_q,
    output dma_cfg_t          dma_q
);

    localparam logic [STAT_W-1:0] KEEP = enable_keep(REVISION);

    dma_cfg_t dma_d;
    logic [STAT_W-1:0] enable_d;

    always_comb begin
        dma_d    = dma_q;
        enable_d = enable_q;
        if (wr_enable) begin
            enable_d = wdata & KEEP;
        end
        if (wr_dma) begin
            dma_d.rx_en = wdata[DMA_RX_POS];
            dma_d.tx_en = wdata[DMA_TX_POS];
            if (wdata[DMA_RX_POS]) enable_d[RX_BIT] = 1'b0;
            if (wdata[DMA_TX_POS]) enable_d[TX_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            dma_q    <= '0;
        end else begin
            enable_q <= enable_d;
            dma_q    <= dma_d;
        end
    end

    a_r7_dma_rx_drops_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wdata[DMA_RX_POS]) |=> !enable_q[RX_BIT]);
    a_r7_dma_tx_drops_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wdata[DMA_TX_POS]) |=> !enable_q[TX_BIT]);

endmodule

// File: rtl/isv_status.sv
module isv_status
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stat_upd_t         upd,
    output logic [STAT_W-1:0] stat_q
);

    logic [STAT_W-1:0] set_eff;

    assign set_eff = upd.set & STORE_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~upd.clr) | set_eff;
        end
    end

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (|set_eff) |=> ((stat_q & $past(set_eff)) == $past(set_eff)));
    a_r9_busy_bit_never_held: assert property (@(posedge clk) disable iff (rst)
        upd.set[BUSY_BIT] |=> !stat_q[BUSY_BIT]);

endmodule

// File: rtl/irq_status_vector.sv
module irq_status_vector
    import isv_pkg::*;
#(
    parameter int REVISION = REV_VECTOR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       evt_set,
    input  logic              rx_rdy_clr,
    input  logic              tx_rdy_clr,
    input  logic              bus_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);

    localparam bit VEC_ON = (REVISION >= REV_VECTOR);

    reg_addr_e         addr;
    logic [STAT_W-1:0] enable_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] pending;
    logic [STAT_W-1:0] vec_onehot;
    logic [IDX_W-1:0]  vec_idx;
    logic [STAT_W-1:0] vec_clr;
    logic              vec_rd;
    dma_cfg_t          dma_q;
    stat_upd_t         upd;

    assign addr    = reg_addr_e'(reg_addr);
    assign pending = stat_q & enable_q;
    assign vec_rd  = reg_rd && (addr == RA_VECTOR);
    assign vec_clr = (VEC_ON && vec_rd) ? vec_onehot : '0;

    isv_cfg_regs #(.REVISION(REVISION)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_enable (reg_wr && (addr == RA_ENABLE)),
        .wr_dma    (reg_wr && (addr == RA_DMA)),
        .wdata     (reg_wdata),
        .enable_q  (enable_q),
        .dma_q     (dma_q)
    );

    isv_prio_enc #(.W(STAT_W), .IW(IDX_W)) u_enc (
        .vec_in   (pending),
        .idx_o    (vec_idx),
        .onehot_o (vec_onehot)
    );

    always_comb begin
        upd.set = evt_set;
        upd.clr = vec_clr;
        if (reg_wr && (addr == RA_STATUS)) begin
            upd.clr = upd.clr | (reg_wdata & SW_CLR_MASK);
        end
        if (rx_rdy_clr) upd.clr = upd.clr | bit_at(RX_BIT);
        if (tx_rdy_clr) upd.clr = upd.clr | bit_at(TX_BIT);
    end

    isv_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .stat_q (stat_q)
    );

    always_comb begin
        unique case (addr)
            RA_ENABLE: reg_rdata = enable_q;
            RA_STATUS: begin
                reg_rdata           = stat_q;
                reg_rdata[BUSY_BIT] = bus_busy;
            end
            RA_VECTOR: reg_rdata = VEC_ON ? STAT_W'(vec_idx) : '0;
            RA_DMA: begin
                reg_rdata             = '0;
                reg_rdata[DMA_RX_POS] = dma_q.rx_en;
                reg_rdata[DMA_TX_POS] = dma_q.tx_en;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq        = |pending;
    assign dma_rx_req = dma_q.rx_en & stat_q[RX_BIT];
    assign dma_tx_req = dma_q.tx_en & stat_q[TX_BIT];

    // R8: requests only accompany the matching ready event
    a_r8_rx_req_needs_ready: assert property (@(posedge clk) disable iff (rst)
        dma_rx_req |-> stat_q[RX_BIT]);
    a_r8_tx_req_needs_ready: assert property (@(posedge clk) disable iff (rst)
        dma_tx_req |-> stat_q[TX_BIT]);
    a_r9_busy_in_status_read: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_STATUS) |-> (reg_rdata[BUSY_BIT] == bus_busy));
    a_r4_ready_not_sw_cleared: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && addr == RA_STATUS && !rx_rdy_clr && !vec_rd) |=> !$fell(stat_q[RX_BIT]));
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && !irq && !dma_rx_req && !dma_tx_req));

    generate
        if (VEC_ON) begin : g_vec_checks
            a_r1_irq_has_vector: assert property (@(posedge clk) disable iff (rst)
                irq |-> (vec_idx != '0));
            a_r2_vector_read_retires: assert property (@(posedge clk) disable iff (rst)
                (vec_rd && (|vec_onehot) && !(|(vec_onehot & evt_set)))
                |=> !(|(stat_q & $past(vec_onehot))));
        end else begin : g_legacy_checks
            a_r3_vector_inert: assert property (@(posedge clk) disable iff (rst)
                vec_rd |-> (reg_rdata == '0));
        end
    endgenerate

endmodule

// File: tb/tb_irq_status_vector.sv
module tb_irq_status_vector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_set = '0;
    logic        rx_rdy_clr = 1'b0;
    logic        tx_rdy_clr = 1'b0;
    logic        bus_busy = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rdata, rdata_l;
    logic        irq, irq_l, dma_rx_req, dma_rx_l, dma_tx_req, dma_tx_l;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    irq_status_vector #(.REVISION(8'h34)) dut (
        .clk(clk), .rst(rst), .evt_set(evt_set), .rx_rdy_clr(rx_rdy_clr),
        .tx_rdy_clr(tx_rdy_clr), .bus_busy(bus_busy), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    irq_status_vector #(.REVISION(8'h20)) dut_legacy (
        .clk(clk), .rst(rst), .evt_set(evt_set), .rx_rdy_clr(rx_rdy_clr),
        .tx_rdy_clr(tx_rdy_clr), .bus_busy(bus_busy), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_l), .irq(irq_l), .dma_rx_req(dma_rx_l), .dma_tx_req(dma_tx_l)
    );

    localparam logic [1:0] A_EN = 2'd0, A_ST = 2'd1, A_VEC = 2'd2, A_DMA = 2'd3;

    typedef struct packed {
        logic [15:0] evt;
        logic [15:0] en;
        logic [4:0]  vec;
    } row_t;

    localparam row_t ROWS [0:7] = '{
        '{16'h0001, 16'h003F, 5'd1},
        '{16'h0024, 16'h003F, 5'd3},
        '{16'h0030, 16'h0010, 5'd5},
        '{16'h0000, 16'h003F, 5'd0},
        '{16'h00C0, 16'h003F, 5'd0},
        '{16'h0020, 16'h0020, 5'd6},
        '{16'h001E, 16'h0018, 5'd4},
        '{16'h1000, 16'h003F, 5'd0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d, output logic [15:0] dl);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1; d = rdata; dl = rdata_l;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk); evt_set = e;
        @(negedge clk); evt_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d, dl, st_exp;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check("R11 irq", {15'd0, irq}, 16'd0);
        check("R11 dma", {14'd0, dma_rx_req, dma_tx_req}, 16'd0);
        rd(A_ST, d, dl);   check("R11 status", d, 16'h0000);
        rd(A_EN, d, dl);   check("R11 enable", d, 16'h0000);
        rd(A_DMA, d, dl);  check("R11 dma cfg", d, 16'h0000);
        bus_busy = 1'b1;
        rd(A_ST, d, dl);   check("R9 busy shown", d, 16'h1000);
        bus_busy = 1'b0;

        // Table walk: R1, R2, R9 (bit 12 ignored), R3 on legacy copy
        foreach (ROWS[i]) begin
            do_reset();
            wr(A_EN, ROWS[i].en);
            pulse(ROWS[i].evt);
            #1;
            check("R1 irq", {15'd0, irq}, {15'd0, |(ROWS[i].evt & ROWS[i].en & 16'h2FFF & 16'h003F)});
            check("R1 legacy irq", {15'd0, irq_l}, {15'd0, |(ROWS[i].evt & ROWS[i].en & 16'h001F)});
            rd(A_VEC, d, dl);
            check("R2 vector", d, {11'd0, ROWS[i].vec});
            check("R3 legacy vector", dl, 16'h0000);
            st_exp = ROWS[i].evt & 16'hEFFF;
            rd(A_ST, d, dl);
            check("R3 legacy status kept", dl, st_exp);
            if (ROWS[i].vec != 0) st_exp = st_exp & ~(16'h1 << (ROWS[i].vec - 1));
            check("R2 status after vector", d, st_exp);
        end

        // R6: enable width per revision
        do_reset();
        wr(A_EN, 16'hFFFF);
        rd(A_EN, d, dl);
        check("R6 enable new", d, 16'h003F);
        check("R6 enable legacy", dl, 16'h001F);

        // R7: DMA config keeps bits 15/7 and drops enables 3/4
        wr(A_DMA, 16'hFFFF);
        rd(A_DMA, d, dl);  check("R7 dma cfg", d, 16'h8080);
        rd(A_EN, d, dl);   check("R7 enable trimmed", d, 16'h0027);

        // R8: DMA requests follow ready bits
        pulse(16'h0008);
        #1;
        check("R8 rx req", {14'd0, dma_rx_req, dma_tx_req}, 16'h0002);
        pulse(16'h0010);
        #1;
        check("R8 both req", {14'd0, dma_rx_req, dma_tx_req}, 16'h0003);
        @(negedge clk); rx_rdy_clr = 1'b1;
        @(negedge clk); rx_rdy_clr = 1'b0;
        #1;
        check("R5 rx clear", {14'd0, dma_rx_req, dma_tx_req}, 16'h0001);
        wr(A_DMA, 16'h0000);
        #1;
        check("R8 tx gated", {14'd0, dma_rx_req, dma_tx_req}, 16'h0000);

        // R4 and R5: software clear mask, hardware ready clears
        do_reset();
        pulse(16'h003F);
        wr(A_ST, 16'hFFFF);
        rd(A_ST, d, dl);   check("R4 w1c mask", d, 16'h0018);
        @(negedge clk); tx_rdy_clr = 1'b1;
        @(negedge clk); tx_rdy_clr = 1'b0;
        rd(A_ST, d, dl);   check("R5 tx clear", d, 16'h0008);

        // R12: vector writes change nothing
        wr(A_EN, 16'h003F);
        wr(A_VEC, 16'hFFFF);
        rd(A_ST, d, dl);   check("R12 status kept", d, 16'h0008);
        rd(A_EN, d, dl);   check("R12 enable kept", d, 16'h003F);

        // R10: set wins over software clear in same cycle
        do_reset();
        @(negedge clk); evt_set = 16'h0001; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 16'h0001;
        @(negedge clk); evt_set = '0; reg_wr = 1'b0;
        rd(A_ST, d, dl);   check("R10 set over w1c", d, 16'h0001);

        // R10: set wins over vector read clear
        wr(A_EN, 16'h003F);
        @(negedge clk); evt_set = 16'h0001; reg_rd = 1'b1; reg_addr = A_VEC;
        #1; check("R2 vector before set", rdata, 16'h0001);
        @(negedge clk); evt_set = '0; reg_rd = 1'b0;
        rd(A_ST, d, dl);   check("R10 set over vector", d, 16'h0001);

        // R10: set wins over hardware ready clear
        @(negedge clk); evt_set = 16'h0008; rx_rdy_clr = 1'b1;
        @(negedge clk); evt_set = '0; rx_rdy_clr = 1'b0;
        rd(A_ST, d, dl);   check("R10 set over rx clear", d, 16'h0009);

        // R11: reset mid-activity
        do_reset();
        #1;
        check("R11 irq after reset", {15'd0, irq}, 16'd0);
        rd(A_ST, d, dl);   check("R11 status after reset", d, 16'h0000);

        finish_run();
    end

endmodule